// File: doc/BRIEF.md
# Iterative Step Divider

This block is an unsigned divider that a sequencer drives one micro-operation at a time. An *init* operation loads a partial dividend and a divisor, clears the quotient and makes one aligned restoring subtraction. Each following *step* operation receives the full dividend word and a count of low-order dividend bits that are still unconsumed. It shifts those bits into the partial remainder, most significant first, until the partial remainder reaches the divisor or the count runs out. It then makes one more aligned subtraction. The quotient, remainder and divisor stay in internal registers between operations.

Every subtraction lines up the divisor's leading one with the leading one of the partial remainder. If that shifted divisor is too large, it drops back by one place. A single operation can therefore retire one or two quotient bits, and a step can also consume several dividend bits. Each operation finishes in one clock. The step returns the remaining bit count and can update a zero flag, so the outer loop knows when to stop. A zero divisor is flagged, and no division is attempted while the flag is set.

Top module: `stepdiv_unit`

## Requirements
- R1: After reset, `resValid`, `zeroFlag` and `divByZero` are 0, and `quotient`, `remainder` and `bitsLeft` are all zero.
- R2: An init (`opValid`=1, `opStep`=0) sets the quotient to 0, takes `opA` as the partial remainder and stores `opB` as the divisor. It then makes one aligned subtraction. The results appear one clock after the operation. An init does not change `bitsLeft` or `zeroFlag`.
- R3: If the divisor is greater than the partial remainder, the aligned subtraction leaves the quotient and the remainder unchanged (for example, init 5 by 9 gives quotient 0 and remainder 5).
- R4: Otherwise the divisor is shifted left by the difference of the two leading-one positions. If that value exceeds the partial remainder, the shift is reduced by one. The bit 2^shift is added to the quotient, and the shifted divisor is subtracted from the remainder (for example, init 100 by 7 gives quotient 8 and remainder 44).
- R5: A step (`opValid`=1, `opStep`=1) with count c, where 1 ≤ c ≤ DATA_W, repeats one action while the remainder is below the divisor and c is nonzero. The action shifts bit c−1 of `opA` into the low end of the remainder, shifts the quotient left by one and decrements c. After that the step makes one aligned subtraction as in R3/R4.
- R6: A step whose count is 0 leaves the quotient and the remainder unchanged and sets `bitsLeft` to 0.
- R7: After a step, `bitsLeft` holds the count that remains after the shifting in R5. It never exceeds the count that was supplied.
- R8: On a step with `zfEnable`=1, `zeroFlag` becomes 1 if the new remaining count is 0 and 0 otherwise. On a step with `zfEnable`=0, and on any init, `zeroFlag` keeps its value.
- R9: An init with `opB`=0 sets `divByZero` and performs no subtraction (quotient 0, remainder `opA`). An init with a nonzero divisor clears the flag. While the flag is set, a step leaves the quotient and the remainder unchanged and returns its supplied count on `bitsLeft`.
- R10: `resValid` is high for exactly the clock after each accepted operation and low after a cycle without one.
- R11: The sequence is init with (dividend >> k) and divisor d, then steps with the dividend and the returned count until that count is 0, where 1 ≤ k ≤ DATA_W and 0 < d ≤ 2^(DATA_W−1). At the end of this sequence, `quotient` equals dividend / d and `remainder` equals dividend mod d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opStep | input | 1 | 0 = init, 1 = step |
| opA | input | DATA_W | Init: partial dividend; step: dividend word to draw bits from |
| opB | input | DATA_W | Init: divisor (ignored on step) |
| bitCount | input | CNT_W | Step: count of dividend bits still to consume |
| zfEnable | input | 1 | Step: allow `zeroFlag` to be updated |
| resValid | output | 1 | Result strobe, one clock after an operation |
| bitsLeft | output | CNT_W | Remaining count after the last step |
| zeroFlag | output | 1 | Set when the remaining count reached zero |
| divByZero | output | 1 | Stored divisor is zero |
| quotient | output | DATA_W | Quotient register |
| remainder | output | DATA_W | Remainder register |

## Verification
Directed cases separate the three outcomes of an aligned subtraction: no subtraction because the divisor is larger, an exact alignment, and an alignment that must back off by one place. A step that shifts in several bits before it can subtract shows whether bits are taken from the right source index. Steps with a zero count, with the flag enable off, and after a zero-divisor init show whether state is held where it must be. Full random divisions with random divisor sizes and random split points then compare the final quotient and remainder with exact integer division. This catches misordered bits and lost quotient bits that the single-step cases would not show.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
  // Strobes from the control to the datapath, one set per clock.
  typedef struct packed {
    logic loadInit;   // load operands and make the first subtraction
    logic applyStep;  // shift in bits and subtract
    logic updLeft;    // write the remaining-count register
    logic leftPass;   // remaining count is the supplied count unchanged
  } divCtrl_t;
endpackage

// File: rtl/stepdiv_leadone.sv
module stepdiv_leadone #(
  parameter int W = 64,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [LW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = LW'(i);
    end
  end
endmodule

// File: rtl/stepdiv_align.sv
module stepdiv_align #(
  parameter int W = 64,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0] partIn,
  input  logic [W-1:0] quoIn,
  input  logic [W-1:0] dvsIn,
  output logic [W-1:0] quoOut,
  output logic [W-1:0] remOut
);
  logic [LW-1:0] msbPart, msbDvs, shAmt;
  logic [W-1:0]  shDvs, qBit;

  stepdiv_leadone #(.W(W)) uPart (.vec(partIn), .pos(msbPart));
  stepdiv_leadone #(.W(W)) uDvs  (.vec(dvsIn),  .pos(msbDvs));

  always_comb begin
    shAmt  = msbPart - msbDvs;
    shDvs  = dvsIn << shAmt;
    qBit   = {{(W-1){1'b0}}, 1'b1} << shAmt;
    quoOut = quoIn;
    remOut = partIn;
    if (dvsIn != '0 && partIn >= dvsIn) begin
      if (shDvs > partIn) begin
        shDvs = shDvs >> 1;
        qBit  = qBit >> 1;
      end
      quoOut = quoIn + qBit;
      remOut = partIn - shDvs;
    end
  end
endmodule

// File: rtl/stepdiv_datapath.sv
module stepdiv_datapath
  import stepdiv_pkg::*;
#(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1),
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  divCtrl_t      ctrl,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [CW-1:0] bitCount,
  output logic          dvsInZero,
  output logic [CW-1:0] nextLeft,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder,
  output logic [CW-1:0] bitsLeft
);
  logic [W-1:0]  quoReg, remReg, dvsReg;
  logic [CW-1:0] leftReg;
  logic [W-1:0]  partSh, quoSh;
  logic [CW-1:0] cntSh;
  logic [W-1:0]  alPart, alQuo, alDvs, alQuoOut, alRemOut;

  assign dvsInZero = (opB == '0);

  // Shift in unconsumed dividend bits until the remainder reaches the divisor.
  always_comb begin
    logic [LW-1:0] idx;
    partSh = remReg;
    quoSh  = quoReg;
    cntSh  = (bitCount > CW'(W)) ? CW'(W) : bitCount;
    idx    = '0;
    for (int i = 0; i < W; i++) begin
      if (partSh < dvsReg && cntSh != '0) begin
        idx    = LW'(cntSh - 1'b1);
        partSh = {partSh[W-2:0], opA[idx]};
        quoSh  = {quoSh[W-2:0], 1'b0};
        cntSh  = cntSh - 1'b1;
      end
    end
  end

  assign nextLeft = ctrl.leftPass ? bitCount : cntSh;

  always_comb begin
    if (ctrl.loadInit) begin
      alPart = opA;
      alQuo  = '0;
      alDvs  = opB;
    end else begin
      alPart = partSh;
      alQuo  = quoSh;
      alDvs  = dvsReg;
    end
  end

  stepdiv_align #(.W(W)) uAlign (
    .partIn(alPart), .quoIn(alQuo), .dvsIn(alDvs),
    .quoOut(alQuoOut), .remOut(alRemOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoReg  <= '0;
      remReg  <= '0;
      dvsReg  <= '0;
      leftReg <= '0;
    end else begin
      if (ctrl.loadInit) begin
        quoReg <= alQuoOut;
        remReg <= alRemOut;
        dvsReg <= opB;
      end else if (ctrl.applyStep) begin
        quoReg <= alQuoOut;
        remReg <= alRemOut;
      end
      if (ctrl.updLeft) leftReg <= nextLeft;
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg;
  assign bitsLeft  = leftReg;

  // R6: a zero-count step touches neither quotient nor remainder
  assert_zero_count_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.updLeft && !ctrl.loadInit && bitCount == '0) |=> ($stable(quoReg) && $stable(remReg)));

  // R7: the remaining count never grows
  assert_left_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.updLeft |=> (leftReg <= $past(bitCount)));

  // R3: an init whose divisor exceeds the dividend makes no subtraction
  assert_init_no_sub_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadInit && opB > opA) |=> (quoReg == '0 && remReg == $past(opA)));

  // R2: after a nonzero-divisor init the remainder is below the dividend loaded
  assert_init_reduces_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadInit && opB != '0 && opB <= opA) |=> (remReg < $past(opA) && quoReg != '0));
endmodule

// File: rtl/stepdiv_ctrl.sv
module stepdiv_ctrl
  import stepdiv_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic          opStep,
  input  logic [CW-1:0] bitCount,
  input  logic          zfEnable,
  input  logic          dvsInZero,
  input  logic [CW-1:0] nextLeft,
  output divCtrl_t      ctrl,
  output logic          resValid,
  output logic          zeroFlag,
  output logic          divByZero
);
  logic isInit, isStep, errReg;

  assign isInit = opValid && !opStep;
  assign isStep = opValid && opStep;

  always_comb begin
    ctrl.loadInit  = isInit;
    ctrl.updLeft   = isStep;
    ctrl.leftPass  = isStep && errReg;
    ctrl.applyStep = isStep && !errReg && (bitCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      zeroFlag <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      resValid <= opValid;
      if (isInit) errReg <= dvsInZero;
      if (isStep && zfEnable) zeroFlag <= (nextLeft == '0);
    end
  end

  assign divByZero = errReg;

  // R9: a zero-divisor init raises the error flag
  assert_zero_divisor_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isInit && dvsInZero) |=> divByZero);

  // R8: the zero flag moves only on an enabled step
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(isStep && zfEnable) |=> $stable(zeroFlag));

  // R10: no strobe after an idle cycle
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);
endmodule

// File: rtl/stepdiv_unit.sv
module stepdiv_unit #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opStep,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic              zfEnable,
  output logic              resValid,
  output logic [CNT_W-1:0]  bitsLeft,
  output logic              zeroFlag,
  output logic              divByZero,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);
  stepdiv_pkg::divCtrl_t ctrl;
  logic                  dvsInZero;
  logic [CNT_W-1:0]      nextLeft;

  stepdiv_ctrl #(.CW(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opStep(opStep),
    .bitCount(bitCount), .zfEnable(zfEnable), .dvsInZero(dvsInZero),
    .nextLeft(nextLeft), .ctrl(ctrl), .resValid(resValid),
    .zeroFlag(zeroFlag), .divByZero(divByZero)
  );

  stepdiv_datapath #(.W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .bitCount(bitCount), .dvsInZero(dvsInZero), .nextLeft(nextLeft),
    .quotient(quotient), .remainder(remainder), .bitsLeft(bitsLeft)
  );
endmodule

// File: tb/tb_stepdiv_unit.sv
module tb_stepdiv_unit;
  localparam int W  = 64;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0, opStep = 1'b0, zfEnable = 1'b0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic [CW-1:0] bitCount = '0;
  logic          resValid, zeroFlag, divByZero;
  logic [CW-1:0] bitsLeft;
  logic [W-1:0]  quotient, remainder;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  // behavioural reference state
  longint unsigned mQ = 0, mR = 0, mD = 0;
  int  mLeft = 0;
  bit  mZ = 0, mErr = 0, mValid = 0;

  stepdiv_unit #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opStep(opStep), .opA(opA),
    .opB(opB), .bitCount(bitCount), .zfEnable(zfEnable), .resValid(resValid),
    .bitsLeft(bitsLeft), .zeroFlag(zeroFlag), .divByZero(divByZero),
    .quotient(quotient), .remainder(remainder)
  );

  always #2.5 clk = ~clk;

  function automatic int topBit(longint unsigned v);
    int p = 0;
    for (int i = 0; i < 64; i++) if (v[i]) p = i;
    return p;
  endfunction

  task automatic cmp(string tag, string what, longint unsigned act, longint unsigned exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    cmp("R10", "resValid", resValid, mValid);
    cmp(tag, "bitsLeft", bitsLeft, mLeft);
    cmp(tag, "zeroFlag", zeroFlag, mZ);
    cmp(tag, "divByZero", divByZero, mErr);
    cmp(tag, "quotient", quotient, mQ);
    cmp(tag, "remainder", remainder, mR);
  endtask

  task automatic modelSub(longint unsigned p, longint unsigned q);
    longint unsigned sd, qb;
    int sh;
    if (mD != 0 && p >= mD) begin
      sh = topBit(p) - topBit(mD);
      sd = mD << sh;
      qb = 64'd1 << sh;
      if (sd > p) begin sd = sd >> 1; qb = qb >> 1; end
      mQ = q + qb;
      mR = p - sd;
    end else begin
      mQ = q;
      mR = p;
    end
  endtask

  task automatic doInit(string tag, longint unsigned a, longint unsigned b);
    opValid = 1; opStep = 0; opA = a; opB = b; bitCount = '0; zfEnable = 0;
    mD = b; mErr = (b == 0);
    modelSub(a, 0);
    mValid = 1;
    @(negedge clk);
    checkAll(tag);
    opValid = 0; mValid = 0;
  endtask

  task automatic doStep(string tag, longint unsigned src, int cnt, bit zfe);
    longint unsigned p, q;
    int c;
    opValid = 1; opStep = 1; opA = src; opB = '0; bitCount = CW'(cnt); zfEnable = zfe;
    if (mErr) mLeft = cnt;
    else if (cnt == 0) mLeft = 0;
    else begin
      p = mR; q = mQ; c = cnt;
      while (p < mD && c > 0) begin
        p = (p << 1) | ((src >> (c - 1)) & 64'd1);
        q = q << 1;
        c--;
      end
      modelSub(p, q);
      mLeft = c;
    end
    if (zfe) mZ = (mLeft == 0);
    mValid = 1;
    @(negedge clk);
    checkAll(tag);
    opValid = 0; mValid = 0;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic runDivide(longint unsigned dvd, longint unsigned dvs, int k);
    int left = k, guard = 0;
    doInit("R11", (k >= 64) ? 64'd0 : (dvd >> k), dvs);
    while (left != 0 && guard < 300) begin
      doStep("R11", dvd, left, 1);
      left = mLeft;
      guard++;
    end
    doStep("R6", dvd, 0, 1);
    cmp("R11", "final quotient", quotient, dvd / dvs);
    cmp("R11", "final remainder", remainder, dvd % dvs);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChk++; nFail++;
    $display("FAIL R10 watchdog: actual=hung expected=complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    idle("R1");
    // R2/R4: 100 / 7 backs off one place: quotient 8, remainder 44
    doInit("R4", 64'd100, 64'd7);
    cmp("R4", "q 100/7", quotient, 64'd8);
    cmp("R4", "r 100/7", remainder, 64'd44);
    idle("R10");
    // R4: exact alignment 12 / 3 -> shift 2, quotient 4, remainder 0
    doInit("R2", 64'd12, 64'd3);
    // R3: divisor larger
    doInit("R3", 64'd5, 64'd9);
    // R5/R7: shift in bit 3 of 1011b, then subtract
    doStep("R5", 64'hB, 4, 1);
    cmp("R7", "bitsLeft after 1 bit", bitsLeft, 3);
    cmp("R5", "q after step", quotient, 64'd1);
    cmp("R5", "r after step", remainder, 64'd2);
    // R8: enable off holds flag, enable on updates
    doStep("R8", 64'hB, 3, 0);
    doStep("R8", 64'hB, mLeft, 1);
    doStep("R8", 64'hB, 2, 0);
    doInit("R8", 64'd40, 64'd3);
    // R6: zero count changes nothing
    doStep("R6", 64'hFFFF, 0, 1);
    doStep("R6", 64'h0, 0, 0);
    // R9: zero divisor
    doInit("R9", 64'd77, 64'd0);
    doStep("R9", 64'hFF, 5, 1);
    doStep("R9", 64'hFF, 0, 1);
    doInit("R9", 64'd77, 64'd10);
    idle("R10");
    // R11: directed and random full divisions
    runDivide(64'd1000, 64'd7, 8);
    runDivide(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64);
    runDivide(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1);
    runDivide(64'd6, 64'd7, 3);
    for (int n = 0; n < 40; n++) begin
      longint unsigned a, d;
      a = {$urandom, $urandom};
      d = {$urandom, $urandom} >> $urandom_range(1, 63);
      if (d == 0) d = 64'd3;
      runDivide(a, d, $urandom_range(1, 64));
      idle("R10");
    end
    finishRun();
  end
endmodule